// File: doc/BRIEF.md
# Sequential Prefetch Buffer

This block sits beside a first-level cache and keeps a tiny fully associative store of blocks that were read from lower memory in advance. When the cache reports a miss, the block address is matched against every buffer entry at once. A match costs one extra cycle: the stored block is presented on the cache write port, the miss is answered, and the entry is dropped. Without a match, the block is read from lower memory through a request/grant/return handshake and passed straight to the cache write port when it returns.

Once a miss has been answered and the processor is running again, the controller considers the block that follows the missed one. It asks the cache through a probe port whether that block is already resident and also checks its own entries. If neither holds it, the block is read into the buffer. That read is only placed on the memory port while no demand miss is waiting. A pending read that has not been granted is withdrawn when a miss arrives. A read that has been granted is allowed to finish into the buffer first.

Top module: `prefetch_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req`, `fill_valid`, `resp_valid` and `probe_valid` are low.
- R2: A miss whose block address matches a valid buffer entry is answered exactly one cycle after `miss_valid` is sampled, with `resp_from_buf`=1, `fill_valid`=1, `fill_addr` equal to the missed block address and `fill_data` equal to the stored data. No memory read is made for it.
- R3: A miss that matches no valid entry raises `mem_req` with `mem_addr` equal to the missed block address. The returned `mem_rdata` is put on `fill_data` in the same cycle as `mem_rvalid`, together with `fill_valid`=1, `resp_valid`=1 and `resp_from_buf`=0.
- R4: In the cycle after a response, `probe_valid` is high with `probe_addr` equal to the missed address plus one, modulo 2^AW. If that block is not present, exactly one memory read of it follows and its data is kept in the buffer.
- R5: No prefetch read is made when `probe_hit` is high in the probe cycle, or when the next block is already a valid buffer entry.
- R6: When `miss_valid` is high while a prefetch read is requested but not granted, `mem_req` drops in that same cycle, and the prefetch is abandoned.
- R7: A prefetch read that has already been granted completes into the buffer before a miss that arrives during it is looked up, so a miss on that same block is served from the buffer.
- R8: The buffer holds NENT entries that are written in rotating (FIFO) order, so the oldest write is overwritten. An entry is invalidated when it is moved into the cache, and a repeat miss on that block then goes to memory.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_addr` does not change until the request is either granted or withdrawn.
- R10: `fill_valid` is never high in two consecutive cycles; each miss makes exactly one cache write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Cache miss pending. Held high until the cycle in which `resp_valid` is seen |
| miss_addr | input | AW | Block address of the miss |
| resp_valid | output | 1 | The miss is resolved in this cycle |
| resp_from_buf | output | 1 | The resolved block came from the buffer |
| fill_valid | output | 1 | Cache write strobe |
| fill_addr | output | AW | Block address written into the cache |
| fill_data | output | DW | Block data written into the cache |
| mem_req | output | 1 | Lower-memory read request |
| mem_addr | output | AW | Block address of the memory read |
| mem_gnt | input | 1 | Request accepted; one read outstanding |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DW | Returned block data |
| probe_valid | output | 1 | Asks the cache whether `probe_addr` is resident |
| probe_addr | output | AW | Next-block address being probed |
| probe_hit | input | 1 | The cache holds `probe_addr`; sampled in the same cycle |

## Verification
The bench builds the block with AW=6, DW=16 and NENT=2. Six address bits let a miss on block 63 prefetch block 0, which exercises the wraparound of the next-block address. With only two entries, a handful of prefetches is enough to overwrite entries in rotating order, so the replacement order and invalidation after use can both be observed through which misses later hit. The memory model's read latency and selective grant blocking are varied at run time, which opens both the cancelled-before-grant case and the completed-after-grant case.

// File: rtl/pfbuf_pkg.sv
package pfbuf_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_HIT_WR   = 3'd1,
        S_DEM_REQ  = 3'd2,
        S_DEM_WAIT = 3'd3,
        S_PF_CHK   = 3'd4,
        S_PF_REQ   = 3'd5,
        S_PF_WAIT  = 3'd6
    } state_e;

endpackage

// File: rtl/pfbuf_store.sv
module pfbuf_store #(
    parameter int NENT = 2,
    parameter int AW   = 26,
    parameter int DW   = 64,
    parameter int IW   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_tag,
    output logic          lk_hit,
    output logic [IW-1:0] lk_idx,
    output logic [DW-1:0] lk_data,
    input  logic [AW-1:0] pk_tag,
    output logic          pk_hit,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data,
    input  logic          inv_en,
    input  logic [IW-1:0] inv_idx
);

    logic [NENT-1:0] vld_q, vld_d;
    logic [AW-1:0]   tag_q  [NENT];
    logic [AW-1:0]   tag_d  [NENT];
    logic [DW-1:0]   data_q [NENT];
    logic [DW-1:0]   data_d [NENT];
    logic [IW-1:0]   ptr_q, ptr_d;

    logic [NENT-1:0] lk_match;
    logic [NENT-1:0] pk_match;

    // one comparator pair per entry, searched in parallel
    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_tag);
        assign pk_match[g] = vld_q[g] && (tag_q[g] == pk_tag);
    end

    assign lk_hit = |lk_match;
    assign pk_hit = |pk_match;

    always_comb begin
        lk_idx  = '0;
        lk_data = '0;
        for (int i = 0; i < NENT; i++) begin
            if (lk_match[i]) begin
                lk_idx  = IW'(i);
                lk_data = data_q[i];
            end
        end
    end

    always_comb begin
        vld_d  = vld_q;
        tag_d  = tag_q;
        data_d = data_q;
        ptr_d  = ptr_q;
        if (inv_en) begin
            vld_d[inv_idx] = 1'b0;
        end
        if (wr_en) begin
            vld_d[ptr_q]  = 1'b1;
            tag_d[ptr_q]  = wr_tag;
            data_d[ptr_q] = wr_data;
            ptr_d = (ptr_q == IW'(NENT - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            vld_q <= vld_d;
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        data_q <= data_d;
    end

endmodule

// File: rtl/pfbuf_ctrl.sv
module pfbuf_ctrl
    import pfbuf_pkg::*;
#(
    parameter int AW = 26,
    parameter int DW = 64,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          resp_valid,
    output logic          resp_from_buf,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          probe_valid,
    output logic [AW-1:0] probe_addr,
    input  logic          probe_hit,
    output logic [AW-1:0] lk_tag,
    input  logic          lk_hit,
    input  logic [IW-1:0] lk_idx,
    input  logic [DW-1:0] lk_data,
    output logic [AW-1:0] pk_tag,
    input  logic          pk_hit,
    output logic          wr_en,
    output logic [AW-1:0] wr_tag,
    output logic [DW-1:0] wr_data,
    output logic          inv_en,
    output logic [IW-1:0] inv_idx
);

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] addr;
        logic [AW-1:0] pf_addr;
        logic [IW-1:0] hit_idx;
        logic [DW-1:0] hit_data;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d           = r_q;
        resp_valid    = 1'b0;
        resp_from_buf = 1'b0;
        fill_valid    = 1'b0;
        fill_addr     = r_q.addr;
        fill_data     = r_q.hit_data;
        mem_req       = 1'b0;
        mem_addr      = r_q.addr;
        probe_valid   = 1'b0;
        probe_addr    = r_q.pf_addr;
        lk_tag        = miss_addr;
        pk_tag        = r_q.pf_addr;
        wr_en         = 1'b0;
        wr_tag        = r_q.pf_addr;
        wr_data       = mem_rdata;
        inv_en        = 1'b0;
        inv_idx       = r_q.hit_idx;

        unique case (r_q.st)
            S_IDLE: begin
                if (miss_valid) begin
                    r_d.addr     = miss_addr;
                    r_d.pf_addr  = miss_addr + AW'(1);
                    r_d.hit_idx  = lk_idx;
                    r_d.hit_data = lk_data;
                    r_d.st       = lk_hit ? S_HIT_WR : S_DEM_REQ;
                end
            end
            S_HIT_WR: begin
                // the single extra cycle: write the buffered block into the cache
                fill_valid    = 1'b1;
                resp_valid    = 1'b1;
                resp_from_buf = 1'b1;
                inv_en        = 1'b1;
                r_d.st        = S_PF_CHK;
            end
            S_DEM_REQ: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    r_d.st = S_DEM_WAIT;
                end
            end
            S_DEM_WAIT: begin
                fill_data = mem_rdata;
                if (mem_rvalid) begin
                    fill_valid = 1'b1;
                    resp_valid = 1'b1;
                    r_d.st     = S_PF_CHK;
                end
            end
            S_PF_CHK: begin
                probe_valid = 1'b1;
                if (miss_valid || probe_hit || pk_hit) begin
                    r_d.st = S_IDLE;
                end else begin
                    r_d.st = S_PF_REQ;
                end
            end
            S_PF_REQ: begin
                mem_addr = r_q.pf_addr;
                if (miss_valid) begin
                    r_d.st = S_IDLE;
                end else begin
                    mem_req = 1'b1;
                    if (mem_gnt) begin
                        r_d.st = S_PF_WAIT;
                    end
                end
            end
            S_PF_WAIT: begin
                mem_addr = r_q.pf_addr;
                if (mem_rvalid) begin
                    wr_en  = 1'b1;
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/prefetch_buffer.sv
module prefetch_buffer #(
    parameter int AW   = 26,
    parameter int DW   = 64,
    parameter int NENT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          resp_valid,
    output logic          resp_from_buf,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          probe_valid,
    output logic [AW-1:0] probe_addr,
    input  logic          probe_hit
);

    localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;

    logic [AW-1:0] lk_tag;
    logic          lk_hit;
    logic [IW-1:0] lk_idx;
    logic [DW-1:0] lk_data;
    logic [AW-1:0] pk_tag;
    logic          pk_hit;
    logic          wr_en;
    logic [AW-1:0] wr_tag;
    logic [DW-1:0] wr_data;
    logic          inv_en;
    logic [IW-1:0] inv_idx;

    pfbuf_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_addr     (miss_addr),
        .resp_valid    (resp_valid),
        .resp_from_buf (resp_from_buf),
        .fill_valid    (fill_valid),
        .fill_addr     (fill_addr),
        .fill_data     (fill_data),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .probe_valid   (probe_valid),
        .probe_addr    (probe_addr),
        .probe_hit     (probe_hit),
        .lk_tag        (lk_tag),
        .lk_hit        (lk_hit),
        .lk_idx        (lk_idx),
        .lk_data       (lk_data),
        .pk_tag        (pk_tag),
        .pk_hit        (pk_hit),
        .wr_en         (wr_en),
        .wr_tag        (wr_tag),
        .wr_data       (wr_data),
        .inv_en        (inv_en),
        .inv_idx       (inv_idx)
    );

    pfbuf_store #(.NENT(NENT), .AW(AW), .DW(DW), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_tag  (lk_tag),
        .lk_hit  (lk_hit),
        .lk_idx  (lk_idx),
        .lk_data (lk_data),
        .pk_tag  (pk_tag),
        .pk_hit  (pk_hit),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .inv_en  (inv_en),
        .inv_idx (inv_idx)
    );

endmodule

// File: rtl/pfbuf_chk.sv
module pfbuf_chk #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          fill_valid,
    input logic          resp_valid,
    input logic          resp_from_buf,
    input logic          probe_valid
);

    AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (!mem_req || $stable(mem_addr))); // R9

    AST_BUF_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_from_buf) |-> !mem_req); // R2

    AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid); // R10

    AST_PROBE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> probe_valid); // R4

    AST_NO_READ_IN_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !mem_req); // R4

endmodule

bind prefetch_buffer pfbuf_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_addr      (mem_addr),
    .fill_valid    (fill_valid),
    .resp_valid    (resp_valid),
    .resp_from_buf (resp_from_buf),
    .probe_valid   (probe_valid)
);

// File: tb/prefetch_buffer_test.sv
module prefetch_buffer_test;

    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int NENT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          resp_valid, resp_from_buf, fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          probe_valid;
    logic [AW-1:0] probe_addr;
    logic          probe_hit = 1'b0;

    int checks = 0;
    int errors = 0;

    // memory model controls
    int            rd_lat = 1;
    int            rd_cnt = 0;
    int            gcount = 0;
    logic          blk_en = 1'b0;
    logic [AW-1:0] blk_addr = '0;
    logic [AW-1:0] lat_addr = '0;

    always #4 clk = ~clk;

    prefetch_buffer #(.AW(AW), .DW(DW), .NENT(NENT)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_addr     (miss_addr),
        .resp_valid    (resp_valid),
        .resp_from_buf (resp_from_buf),
        .fill_valid    (fill_valid),
        .fill_addr     (fill_addr),
        .fill_data     (fill_data),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .probe_valid   (probe_valid),
        .probe_addr    (probe_addr),
        .probe_hit     (probe_hit)
    );

    function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
        return {a, 4'hC, a} ^ 16'h5A5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // lower-memory responder: grants one read at a time, returns after rd_lat cycles
    initial begin
        forever begin
            @(negedge clk);
            #1;
            mem_gnt    = 1'b0;
            mem_rvalid = 1'b0;
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = dat(lat_addr);
                end
            end else if (mem_req && !(blk_en && mem_addr == blk_addr)) begin
                mem_gnt  = 1'b1;
                lat_addr = mem_addr;
                gcount++;
                rd_cnt   = rd_lat;
            end
        end
    end

    task automatic wait_resp(input logic [AW-1:0] a, input bit eb, input int elat);
        int cyc = 0;
        bit got = 0;
        for (int k = 0; k < 60 && !got; k++) begin
            @(negedge clk);
            #2;
            cyc++;
            if (resp_valid) begin
                got = 1;
                miss_valid = 1'b0;
                chk(resp_from_buf == eb, "R8 source of block", int'(resp_from_buf), int'(eb));
                chk(fill_valid && fill_addr == a, eb ? "R2 fill addr" : "R3 fill addr",
                    int'(fill_addr), int'(a));
                chk(fill_data == dat(a), eb ? "R2 fill data" : "R3 fill data",
                    int'(fill_data), int'(dat(a)));
                if (elat >= 0) begin
                    chk(cyc == elat, eb ? "R2 latency" : "R3 latency", cyc, elat);
                end
            end
        end
        if (!got) begin
            miss_valid = 1'b0;
            chk(1'b0, "R2 R3 no response", 0, 1);
        end
    endtask

    task automatic do_miss(input logic [AW-1:0] a, input bit nic, input bit eb, input bit settle);
        @(negedge clk);
        gcount     = 0;
        probe_hit  = nic;
        miss_valid = 1'b1;
        miss_addr  = a;
        wait_resp(a, eb, eb ? 1 : 1 + rd_lat);
        if (settle) begin
            repeat (14) @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [AW-1:0] a;
        logic          nic;
        logic          bhit;
        logic [1:0]    gnts;
    } vec_t;

    // address, next block in cache, expect buffer hit, memory reads expected
    localparam vec_t VEC [12] = '{
        '{6'd10, 1'b0, 1'b0, 2'd2},  // R3 demand, R4 prefetch 11
        '{6'd11, 1'b0, 1'b1, 2'd1},  // R2 hit, prefetch 12
        '{6'd12, 1'b1, 1'b1, 2'd0},  // R5 next block in cache, no read
        '{6'd13, 1'b0, 1'b0, 2'd2},  // skipped block goes to memory
        '{6'd30, 1'b0, 1'b0, 2'd2},  // prefetch 31
        '{6'd14, 1'b0, 1'b1, 2'd1},  // hit, prefetch 15
        '{6'd14, 1'b0, 1'b0, 2'd1},  // R8 invalidated; R5 15 already buffered
        '{6'd31, 1'b0, 1'b1, 2'd1},  // hit, prefetch 32
        '{6'd63, 1'b0, 1'b0, 2'd2},  // R4 wraps to block 0
        '{6'd0,  1'b0, 1'b1, 2'd1},  // wrapped prefetch hits
        '{6'd15, 1'b0, 1'b0, 2'd2},  // R8 oldest entry overwritten
        '{6'd32, 1'b0, 1'b0, 2'd2}   // R8 overwritten as well
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mem_req && !fill_valid && !resp_valid && !probe_valid, "R1 outputs in reset",
            int'({mem_req, fill_valid, resp_valid, probe_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!mem_req && !fill_valid && !resp_valid && !probe_valid, "R1 outputs after reset",
            int'({mem_req, fill_valid, resp_valid, probe_valid}), 0);

        foreach (VEC[i]) begin
            do_miss(VEC[i].a, VEC[i].nic, VEC[i].bhit, 1'b1);
            chk(gcount == int'(VEC[i].gnts), "R4 R5 memory reads per miss", gcount, int'(VEC[i].gnts));
        end

        // R6: ungranted prefetch withdrawn by a demand miss
        blk_en   = 1'b1;
        blk_addr = 6'd41;
        do_miss(6'd40, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        #2;
        chk(mem_req && mem_addr == 6'd41, "R9 pending prefetch address", int'(mem_addr), 41);
        @(negedge clk);
        #2;
        chk(mem_req && mem_addr == 6'd41, "R9 address held", int'(mem_addr), 41);
        @(negedge clk);
        gcount     = 0;
        miss_valid = 1'b1;
        miss_addr  = 6'd41;
        #2;
        chk(!mem_req, "R6 request dropped for demand", int'(mem_req), 0);
        blk_en = 1'b0;
        wait_resp(6'd41, 1'b0, 2 + rd_lat);
        repeat (14) @(negedge clk);
        chk(gcount == 2, "R6 demand plus next prefetch", gcount, 2);

        // R7: granted prefetch completes before the demand is looked up
        rd_lat = 6;
        do_miss(6'd50, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 20 && gcount < 2; k++) begin
            @(negedge clk);
            #2;
        end
        chk(gcount == 2, "R7 prefetch granted", gcount, 2);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = 6'd51;
        wait_resp(6'd51, 1'b1, -1);
        chk(gcount == 2, "R7 no demand read for in-flight block", gcount, 2);
        repeat (20) @(negedge clk);
        chk(gcount == 3, "R7 following prefetch issued", gcount, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule